// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the word address for a synchronous SRAM during burst accesses. A base address is captured when either of two address strobes is seen on a rising clock edge. One strobe comes from the processor side and one from the memory-controller side. After the capture, the two least significant address bits step through a four-word sequence, one step for each cycle in which the advance input is high. The upper address bits stay frozen until the next capture.

Two burst orders are supported. In linear order, the low bits count upward modulo 4 from the start offset. In interleaved order, they are the start offset XORed with the beat number. The order input is captured together with the address, so a change on that input in the middle of a burst has no effect on the burst in progress.

Bursting is optional. A fresh address may be strobed in on every cycle, and each one appears on the output on the following cycle with no idle cycle in between. The output address and its valid flag are registered, and all inputs are synchronous to the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While synchronous reset is high, on the following edge `cur_addr` becomes 0 and `addr_valid` becomes 0.
- R2: When `proc_strobe` and `chip_en` are both high at a rising edge, `cur_addr` equals `base_addr` and `addr_valid` is 1 after that edge.
- R3: When `ctrl_strobe` and `chip_en` are high and `proc_strobe` is low, `base_addr` is loaded in the same way as in R2. Loads on consecutive cycles each appear one cycle later, with no lost cycle.
- R4: When `proc_strobe` is high and `chip_en` is low, the cycle is ignored: `cur_addr` and `addr_valid` hold their values, even if `ctrl_strobe` is also high.
- R5: When `ctrl_strobe` is high, `proc_strobe` is low and `chip_en` is low, `addr_valid` becomes 0 and `cur_addr` holds its value.
- R6: With `order_linear`=1 at load time, after beat n the low two bits equal (start + n) mod 4.
- R7: With `order_linear`=0 at load time, after beat n the low two bits equal start XOR n. Encoding 0 (interleaved) is the default order.
- R8: The fourth advance after a load returns the low two bits to the start offset, and the sequence repeats.
- R9: Bits `cur_addr[ADDR_W-1:2]` do not change on an advance.
- R10: With no strobe and no advance, the output holds its value. An advance while `addr_valid` is 0 has no effect.
- R11: The burst order is captured at load time. A change of `order_linear` during a burst does not alter that burst.
- R12: A strobe that loads wins over `advance` in the same cycle: the new base address appears and the beat count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, qualifies both strobes |
| proc_strobe | input | 1 | Processor-side address strobe (higher priority) |
| ctrl_strobe | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step the burst by one beat |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| base_addr | input | ADDR_W | External address captured by a load |
| cur_addr | output | ADDR_W | Current word address (registered) |
| addr_valid | output | 1 | Current address is valid (registered) |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a load and an advance. The bench first walks part of a burst. It then raises a strobe together with `advance` and expects the new base address, with no trace of a step, on the next cycle. One further advance must then move from the new start offset.

The second pair is the two strobes. With both strobes high and chip enable low, the processor-side strobe wins, so the controller strobe's deselect must not happen. The bench judges this by seeing that `addr_valid` and the address are unchanged.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DESEL = 2'd2,
    ACT_STEP  = 2'd3
  } action_e;

  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input order_e            ord
  );
    if (ord == ORD_LINEAR) beat_offset = start + beat;
    else                   beat_offset = start ^ beat;
  endfunction

endpackage

// File: rtl/strobe_arb.sv
module strobe_arb
  import burst_pkg::*;
(
  input  logic    chip_en,
  input  logic    proc_strobe,
  input  logic    ctrl_strobe,
  input  logic    advance,
  input  logic    active,
  output action_e action
);

  always_comb begin
    if (proc_strobe) begin
      // processor strobe owns the cycle; without enable it is dropped
      action = chip_en ? ACT_LOAD : ACT_HOLD;
    end else if (ctrl_strobe) begin
      action = chip_en ? ACT_LOAD : ACT_DESEL;
    end else if (advance && active) begin
      action = ACT_STEP;
    end else begin
      action = ACT_HOLD;
    end
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  action_e           action,
  input  logic              order_linear,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              addr_valid
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   upper_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_q;
  order_e            ord_q;
  logic              valid_q;
  logic [BEAT_W-1:0] beat_nx;

  assign beat_nx = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      low_q   <= '0;
      ord_q   <= ORD_INTERLEAVE;
      valid_q <= 1'b0;
    end else begin
      unique case (action)
        ACT_LOAD: begin
          upper_q <= base_addr[ADDR_W-1:BEAT_W];
          start_q <= base_addr[BEAT_W-1:0];
          low_q   <= base_addr[BEAT_W-1:0];
          beat_q  <= '0;
          ord_q   <= order_e'(order_linear);
          valid_q <= 1'b1;
        end
        ACT_STEP: begin
          beat_q <= beat_nx;
          low_q  <= beat_offset(start_q, beat_nx, ord_q);
        end
        ACT_DESEL: valid_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign cur_addr   = {upper_q, low_q};
  assign addr_valid = valid_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              advance,
  input  logic              order_linear,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              addr_valid
);

  action_e action;

  strobe_arb u_arb (
    .chip_en     (chip_en),
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .advance     (advance),
    .active      (addr_valid),
    .action      (action)
  );

  burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .action       (action),
    .order_linear (order_linear),
    .base_addr    (base_addr),
    .cur_addr     (cur_addr),
    .addr_valid   (addr_valid)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en,
  input logic              proc_strobe,
  input logic              ctrl_strobe,
  input logic              advance,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              addr_valid
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!addr_valid && cur_addr == '0));

  assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe && chip_en) |=> (addr_valid && cur_addr == $past(base_addr)));

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe && !proc_strobe && chip_en) |=> (addr_valid && cur_addr == $past(base_addr)));

  assert_proc_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe && !chip_en) |=> ($stable(cur_addr) && $stable(addr_valid)));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe && !proc_strobe && !chip_en) |=> (!addr_valid && $stable(cur_addr)));

  assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (!proc_strobe && !ctrl_strobe) |=> $stable(cur_addr[ADDR_W-1:2]));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!proc_strobe && !ctrl_strobe && (!advance || !addr_valid)) |=>
      ($stable(cur_addr) && $stable(addr_valid)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chip_en     (chip_en),
  .proc_strobe (proc_strobe),
  .ctrl_strobe (ctrl_strobe),
  .advance     (advance),
  .base_addr   (base_addr),
  .cur_addr    (cur_addr),
  .addr_valid  (addr_valid)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_en = 1'b0, proc_strobe = 1'b0, ctrl_strobe = 1'b0;
  logic          advance = 1'b0, order_linear = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          addr_valid;

  int vectors = 0;
  int errs    = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .proc_strobe(proc_strobe),
    .ctrl_strobe(ctrl_strobe), .advance(advance), .order_linear(order_linear),
    .base_addr(base_addr), .cur_addr(cur_addr), .addr_valid(addr_valid)
  );

  task automatic drive(input logic ce, input logic ps, input logic cs,
                       input logic adv, input logic lin, input logic [AW-1:0] a);
    chip_en = ce; proc_strobe = ps; ctrl_strobe = cs;
    advance = adv; order_linear = lin; base_addr = a;
    @(posedge clk); #1;
    chip_en = 1'b0; proc_strobe = 1'b0; ctrl_strobe = 1'b0; advance = 1'b0;
  endtask

  task automatic check(input string req, input logic [AW-1:0] ea, input logic ev);
    vectors++;
    if (cur_addr !== ea || addr_valid !== ev) begin
      errs++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               req, cur_addr, addr_valid, ea, ev);
    end
  endtask

  function automatic logic [AW-1:0] with_low(input logic [AW-1:0] a, input logic [1:0] l);
    return {a[AW-1:2], l};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_linear();
    logic [AW-1:0] b = 19'h4A5B2;
    drive(1, 1, 0, 0, 1, b);
    check("R2", b, 1'b1);
    for (int n = 1; n <= 4; n++) begin
      drive(0, 0, 0, 1, 1, 19'h7FFFF);
      // R6 linear, R9 upper fixed, R8 wrap at n=4
      check(n == 4 ? "R8" : "R6_R9", with_low(b, 2'(b[1:0] + n)), 1'b1);
    end
  endtask

  task automatic t_interleave();
    logic [AW-1:0] b = 19'h1C3D7;
    drive(1, 0, 1, 0, 0, b);
    check("R3", b, 1'b1);
    for (int n = 1; n <= 5; n++) begin
      drive(0, 0, 0, 1, 0, '0);
      check(n == 4 ? "R8" : "R7", with_low(b, b[1:0] ^ 2'(n)), 1'b1);
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] a = cur_addr;
    drive(1, 0, 0, 0, 1, 19'h00001);
    check("R10", a, 1'b1);
    drive(0, 0, 0, 0, 0, 19'h00002);
    check("R10", a, 1'b1);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a = 19'h23450 + 19'(i * 19'h1111);
      drive(1, 0, 1, 0, 1, a);
      check("R3", a, 1'b1);
    end
  endtask

  task automatic t_priority();
    logic [AW-1:0] a = cur_addr;
    drive(0, 1, 1, 0, 0, 19'h55555);
    check("R4", a, 1'b1);
  endtask

  task automatic t_deselect();
    logic [AW-1:0] a = cur_addr;
    drive(0, 0, 1, 0, 0, 19'h12121);
    check("R5", a, 1'b0);
    drive(0, 0, 0, 1, 0, '0);
    check("R10", a, 1'b0);
  endtask

  task automatic t_order_latch();
    logic [AW-1:0] b = 19'h30001;
    drive(1, 1, 0, 0, 1, b);
    check("R2", b, 1'b1);
    drive(0, 0, 0, 1, 0, '0);
    check("R11", with_low(b, 2'd2), 1'b1);
    drive(0, 0, 0, 1, 0, '0);
    check("R11", with_low(b, 2'd3), 1'b1);
  endtask

  task automatic t_load_over_adv();
    logic [AW-1:0] b1 = 19'h0F0F1;
    logic [AW-1:0] b2 = 19'h6ABC6;
    drive(1, 1, 0, 0, 0, b1);
    drive(0, 0, 0, 1, 0, '0);
    check("R7", with_low(b1, 2'd0), 1'b1);
    drive(1, 1, 0, 1, 0, b2);
    check("R12", b2, 1'b1);
    drive(0, 0, 0, 1, 0, '0);
    check("R12", with_low(b2, 2'd3), 1'b1);
  endtask

  initial begin
    fork
      begin
        @(posedge clk); #1;
        t_reset();
        t_linear();
        t_interleave();
        t_hold();
        t_back_to_back();
        t_priority();
        t_deselect();
        t_order_latch();
        t_load_over_adv();
      end
      begin
        repeat (5000) @(posedge clk);
        vectors++;
        errs++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule